// File: doc/BRIEF.md
# Second-Order One-Bit Delta-Sigma DAC Modulator

This block turns a 16-bit unsigned output code into a one-bit stream. The fraction of ones in the stream follows the code. An external switched current source and an RC filter turn the stream into an output current. A two-bit range input selects one of three output spans. Before the code enters the loop, the block rescales it and adds an offset so that the same code span covers each output span. On the live-zero span, code 0 gives one sixth of full density. On the two zero-based spans, code 0 gives zero density.

The loop has two saturating integrators in cascade and a one-bit quantiser. Feedback is plus or minus full scale, and the sign of the second integrator chooses it. A load strobe captures a new code, and the integrators keep running through the load. A clear request drops the held code to the bottom of the span on the next clock, whatever the strobe does in that cycle. One decision leaves the block on every clock.

Top module: `ds2_dac_mod`

## Requirements
- R1: Let F = 24·2^16 be the full-scale level. The loop input level L depends on the held code c and the range select. Range 0b00 (live zero): L = 4·2^16 + 16·c. Range 0b01 (zero-based, 20/24 span): L = 20·c. Range 0b10 (full span): L = 24·c.
- R2: Let u = 2L − F and y = +F when the output bit is 1, −F when it is 0. The output bit is 1 exactly when the second integrator s2 is non-negative. On each clock, s1 ← sat1(s1 + u − y), then s2 ← sat2(s2 + s1new − y).
- R3: s1 saturates to the range [−2^23, 2^23−1] and s2 to [−2^25, 2^25−1]. Neither integrator wraps around.
- R4: The held code changes only on a clock where the load strobe is high, and it then takes the code input. A load does not disturb either integrator.
- R5: When the clear request is high on a clock, the held code becomes 0 on that edge, even if the load strobe is also high.
- R6: A clock with synchronous reset high sets s1, s2 and the held code to 0, so the output bit is 1 in the cycle after reset.
- R7: After 512 settling clocks, the number of ones in the next 4096 clocks is within ±3 of 4096·L/F. This count does not decrease as the code increases within a range.
- R8: After a long run at a span extreme, the loop responds to a new mid-scale code and produces a density that matches R7. It does not lock up.
- R9: Range select 0b11 behaves the same as 0b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_req | input | 1 | Forces the held code to 0 |
| ld_stb | input | 1 | Captures ld_code as the held code |
| ld_code | input | 16 | Unsigned output code |
| rng_sel | input | 2 | Output span select |
| bit_out | output | 1 | One-bit modulator output |

## Verification
The bench runs an integer model of the two integrators next to the design and compares the output bit on every clock. A wrong feedback sign, a wrong integrator order or a wrong range offset therefore shows up within a few cycles. A long run at code 0 on a zero-based span drives the second integrator into its lower limit. A design that wraps instead of clamping would flip sign there and emit ones, and a design that locks up would stay silent after a mid-scale load. The bench also raises the strobe and the clear together, loads codes without a reset, uses range 3, and checks the density across ascending codes. These tests target a clear that loses to the load, integrators that are cleared on a load, an unmapped range, and a non-monotonic mapping.

// File: rtl/ds2_pkg.sv
package ds2_pkg;
   typedef enum logic [1:0] {
      RNG_LIVE4 = 2'b00,
      RNG_Z20   = 2'b01,
      RNG_Z24   = 2'b10,
      RNG_Z24B  = 2'b11
   } rng_e;
endpackage

// File: rtl/ds2_range_map.sv
module ds2_range_map #(
   parameter int CODE_W = 16,
   parameter int VW     = CODE_W + 5
) (
   input  logic [CODE_W-1:0] code,
   input  ds2_pkg::rng_e     rng,
   output logic [VW-1:0]     lvl
);
   localparam logic [VW-1:0] LIVE_OFS = VW'(4) << CODE_W;

   if (VW < CODE_W + 5) begin : g_bad_vw
      $error("ds2_range_map: VW too narrow for 24x code");
   end

   always_comb begin
      unique case (rng)
         ds2_pkg::RNG_LIVE4: lvl = LIVE_OFS + (VW'(code) << 4);
         ds2_pkg::RNG_Z20:   lvl = VW'(code) * VW'(20);
         default:            lvl = VW'(code) * VW'(24);
      endcase
   end
endmodule

// File: rtl/ds2_sat_int.sv
module ds2_sat_int #(
   parameter int W  = 24,
   parameter int FS = 24 << 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic signed [W-1:0] din,
   input  logic                fb_hi,
   output logic signed [W-1:0] q,
   output logic signed [W-1:0] nxt
);
   localparam int SW = W + 2;
   localparam logic signed [SW-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
   localparam logic signed [SW-1:0] SMIN = {3'b111, {(W-1){1'b0}}};
   localparam logic signed [SW-1:0] FSV  = SW'(FS);

   if (FS >= (1 << (W-2))) begin : g_bad_w
      $error("ds2_sat_int: accumulator too narrow for feedback");
   end

   logic signed [SW-1:0] sum;

   always_comb begin
      sum = SW'(q) + SW'(din) + (fb_hi ? -FSV : FSV);
      if (sum > SMAX)      nxt = SMAX[W-1:0];
      else if (sum < SMIN) nxt = SMIN[W-1:0];
      else                 nxt = sum[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (q >= 0 && din >= 0 && !fb_hi) |=> (q >= 0)); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (q < 0 && din < 0 && fb_hi) |=> (q < 0)); // R3
endmodule

// File: rtl/ds2_dac_mod.sv
module ds2_dac_mod #(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_req,
   input  logic              ld_stb,
   input  logic [CODE_W-1:0] ld_code,
   input  logic [1:0]        rng_sel,
   output logic              bit_out
);
   localparam int VW = CODE_W + 5;
   localparam int UW = VW + 2;
   localparam int W1 = VW + 3;
   localparam int W2 = VW + 5;
   localparam int FS = 24 << CODE_W;
   localparam logic signed [W1-1:0] I1_LO = {1'b1, {(W1-1){1'b0}}};
   localparam logic signed [W1-1:0] I1_HI = {1'b0, {(W1-1){1'b1}}};
   localparam logic signed [UW-1:0] U_FS  = UW'(FS);

   if (CODE_W < 4 || CODE_W > 24) begin : g_bad_code_w
      $error("ds2_dac_mod: CODE_W out of supported range");
   end

   logic [CODE_W-1:0]     code_q;
   logic [VW-1:0]         lvl;
   logic signed [UW-1:0]  u;
   logic signed [W1-1:0]  i1_q, i1_nx, i1_din;
   logic signed [W2-1:0]  i2_q, i2_nx, i2_din;

   always_ff @(posedge clk) begin
      if (rst || clr_req) code_q <= '0;
      else if (ld_stb)    code_q <= ld_code;
   end

   ds2_range_map #(.CODE_W(CODE_W), .VW(VW)) u_map (
      .code (code_q),
      .rng  (ds2_pkg::rng_e'(rng_sel)),
      .lvl  (lvl)
   );

   assign u      = $signed({1'b0, lvl, 1'b0}) - U_FS;
   assign i1_din = {{(W1-UW){u[UW-1]}}, u};
   assign i2_din = {{(W2-W1){i1_nx[W1-1]}}, i1_nx};
   assign bit_out = ~i2_q[W2-1];

   ds2_sat_int #(.W(W1), .FS(FS)) u_int1 (
      .clk (clk), .rst (rst), .din (i1_din), .fb_hi (bit_out),
      .q (i1_q), .nxt (i1_nx)
   );

   ds2_sat_int #(.W(W2), .FS(FS)) u_int2 (
      .clk (clk), .rst (rst), .din (i2_din), .fb_hi (bit_out),
      .q (i2_q), .nxt (i2_nx)
   );

   AST_FB_DOWN: assert property (@(posedge clk) disable iff (rst)
      (bit_out && i1_q != I1_LO) |=> (i1_q < $past(i1_q))); // R2
   AST_FB_UP: assert property (@(posedge clk) disable iff (rst)
      (!bit_out && u > -U_FS && i1_q != I1_HI) |=> (i1_q > $past(i1_q))); // R2
   AST_CODE_LOAD: assert property (@(posedge clk) disable iff (rst)
      (ld_stb && !clr_req) |=> (code_q == $past(ld_code))); // R4
   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!ld_stb && !clr_req) |=> $stable(code_q)); // R4
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
      clr_req |=> (code_q == '0)); // R5
endmodule

// File: tb/ds2_dac_mod_tb.sv
module ds2_dac_mod_tb;
   localparam int CLK_P = 10;
   localparam longint F  = 24 * 65536;
   localparam longint S1MAX = (64'sd1 <<< 23) - 1;
   localparam longint S1MIN = -(64'sd1 <<< 23);
   localparam longint S2MAX = (64'sd1 <<< 25) - 1;
   localparam longint S2MIN = -(64'sd1 <<< 25);

   logic clk = 0, rst = 1, clr_req = 0, ld_stb = 0, bit_out;
   logic [15:0] ld_code = 0;
   logic [1:0]  rng_sel = 0;

   int errors = 0, checks = 0;
   string tag = "R6";
   longint m1 = 0, m2 = 0, mcode = 0;

   always #(CLK_P/2) clk = ~clk;

   ds2_dac_mod u_dut (
      .clk(clk), .rst(rst), .clr_req(clr_req), .ld_stb(ld_stb),
      .ld_code(ld_code), .rng_sel(rng_sel), .bit_out(bit_out)
   );

   function automatic longint level(longint c, logic [1:0] r);
      if (r == 2'b00) return 4 * 65536 + 16 * c;
      if (r == 2'b01) return 20 * c;
      return 24 * c;
   endfunction

   function automatic longint clamp(longint v, longint lo, longint hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   task automatic check(string req, longint act, longint exp, bit ok);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      longint u, fb, n1;
      @(posedge clk);
      if (rst) begin
         m1 = 0; m2 = 0; mcode = 0;
      end else begin
         u  = 2 * level(mcode, rng_sel) - F;
         fb = (m2 >= 0) ? F : -F;
         n1 = clamp(m1 + u - fb, S1MIN, S1MAX);
         m2 = clamp(m2 + n1 - fb, S2MIN, S2MAX);
         m1 = n1;
         if (clr_req)     mcode = 0;
         else if (ld_stb) mcode = ld_code;
      end
      @(negedge clk);
      check(tag, bit_out, (m2 >= 0), bit_out == (m2 >= 0));
   endtask

   task automatic load(logic [1:0] r, logic [15:0] c);
      rng_sel = r; ld_code = c; ld_stb = 1;
      tick();
      ld_stb = 0;
   endtask

   task automatic density(string req, logic [1:0] r, logic [15:0] c,
                          logic [1:0] rexp, output int ones);
      longint expn;
      tag = req;
      load(r, c);
      repeat (512) tick();
      ones = 0;
      for (int k = 0; k < 4096; k++) begin
         tick();
         ones += int'(bit_out);
      end
      expn = (4096 * level(c, rexp) + F / 2) / F;
      check(req, ones, expn, (ones >= expn - 3) && (ones <= expn + 3));
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int ones, prev;
      logic [15:0] codes [5] = '{16'd0, 16'd1000, 16'd32768, 16'd50000, 16'd64000};
      @(negedge clk);
      tick(); tick();
      // R6: reset state, output high after reset
      check("R6", bit_out, 1, bit_out == 1'b1);
      rst = 0;
      tag = "R2";
      repeat (20) tick();

      // R1 and R7: density over every range, monotonic in the code
      for (int r = 0; r < 3; r++) begin
         prev = -1;
         for (int i = 0; i < 5; i++) begin
            density("R1", 2'(r), codes[i], 2'(r), ones);
            check("R7", ones, prev, ones >= prev);
            prev = ones;
         end
      end
      density("R7", 2'b00, 16'hFFFF, 2'b00, ones);

      // R9: range 3 aliases the full span
      density("R9", 2'b11, 16'd40000, 2'b10, ones);

      // R4: loads mid-stream with the integrators carried over
      tag = "R4";
      load(2'b01, 16'd12345);
      repeat (7) tick();
      load(2'b01, 16'd54321);
      repeat (30) tick();
      for (int k = 0; k < 4; k++) begin
         ld_code = 16'(k * 999);
         tick();
      end

      // R5: clear beats a simultaneous load
      tag = "R5";
      rng_sel = 2'b00; ld_code = 16'd60000; ld_stb = 1; clr_req = 1;
      tick();
      ld_stb = 0; clr_req = 0;
      repeat (512) tick();
      ones = 0;
      for (int k = 0; k < 4096; k++) begin
         tick();
         ones += int'(bit_out);
      end
      check("R5", ones, 683, (ones >= 680) && (ones <= 686));

      // R3: long run at code 0 on a zero-based span saturates s2
      tag = "R3";
      load(2'b01, 16'd0);
      repeat (8000) tick();
      check("R3", bit_out, 0, bit_out == 1'b0);

      // R8: recovery from the extreme
      density("R8", 2'b01, 16'd32768, 2'b01, ones);
      check("R8", ones, 1, ones > 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule